// File: doc/BRIEF.md
# Serial Receive Queue and Interrupt Controller

This block sits between the receive shift logic of a serial peripheral and a simple word-wide register bus. Frames that the shift logic finishes are offered on a push port and stored in a first-in first-out queue. Software drains the queue by reading a data register. The block reports four interrupt sources:

- a self-clearing level source that follows the queue fill level against a programmable threshold;
- a sticky flag for frames dropped because the queue was full;
- a sticky flag for reads of an empty queue;
- a sticky flag for another master taking over the serial bus. This flag exists only in master builds.

Each source has a raw status bit and an enable bit. The enabled sources are ORed onto one interrupt line. Each sticky flag is cleared by reading its own clear register.

The register bus gives read data combinationally in the same cycle as the select. Read side effects (queue pop, flag clear) and writes take effect at the next rising clock edge.

Top module: `serrx_irq_ctrl`

## Requirements
- R1: Reads of the data register (address 0) return stored frames in push order. The frame sits in the low DATA_W bits and the upper bits are zero.
- R2: Raw status bit 0 (threshold source) is 1 exactly while the fill level is at least the programmed threshold plus one. It clears without software action once reads lower the level.
- R3: The threshold register (address 1) reads back the value written. A written value above DEPTH-1 is stored as DEPTH-1.
- R4: A push while the queue holds DEPTH frames and no data read happens in the same cycle does three things: the frame is dropped, the stored frames are unchanged, and the overflow flag (raw bit 1) is set. A push in the same cycle as a data read of a full queue is accepted.
- R5: Reading address 5 returns the overflow flag in bit 0 and then clears the flag.
- R6: A data read while the queue is empty returns zero and sets the underflow flag (raw bit 2). No stored frame is consumed, so a frame pushed afterwards is the next one read.
- R7: Reading address 6 returns the underflow flag in bit 0 and then clears the flag.
- R8: In a master build, a contention event sets raw bit 3. Reading address 7 returns that flag in bit 0 and then clears it. In other builds the bit reads 0.
- R9: The enable register (address 2, bits 3:0, 1 enables) gates the sources. Address 3 returns raw status and address 4 returns raw AND enable. The interrupt output is high exactly when any enabled source is raw-active.
- R10: When a set event and a read of the matching clear register occur in the same cycle, the flag is 1 afterwards.
- R11: After reset the queue is empty, the threshold and enable registers are 0, all flags are 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Frame offered by receive shift logic |
| push_data | input | DATA_W | Frame value |
| contend_evt | input | 1 | Another master selected this device during a transfer |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the select cycle |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with DEPTH 4, DATA_W 12 and the master option on. The small depth makes the full queue reachable in a few pushes. That brings within reach threshold saturation at 3, overflow with and without a same-cycle pop, and the contention flag. The 12-bit frames expose any stray upper bits in the read data. A queue-based model predicts every read value and the interrupt line on each clock, including the cycles in which a clear and a set coincide.

// File: rtl/serrx_pkg.sv
// Shared register indices and source bit positions for the receive
// interrupt controller. Assumes a 3-bit register index.
package serrx_pkg;
    localparam int ADDR_W = 3;
    localparam int NSRC   = 4;
    localparam int IDX_THR = 0;
    localparam int IDX_OVF = 1;
    localparam int IDX_UNF = 2;
    localparam int IDX_CON = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA    = 3'd0,
        A_THR     = 3'd1,
        A_MASK    = 3'd2,
        A_RAW     = 3'd3,
        A_MSTAT   = 3'd4,
        A_OVF_CLR = 3'd5,
        A_UNF_CLR = 3'd6,
        A_CON_CLR = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/serrx_fifo.sv
// Frame queue: circular buffer of DEPTH entries.
// Assumes pop is only raised when the queue is non-empty (gated by the
// caller). A push to a full queue is dropped unless a pop happens in the
// same cycle; the drop is reported on push_drop.
module serrx_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DATA_W-1:0]            push_data,
    input  logic                         pop,
    output logic [DATA_W-1:0]            head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty,
    output logic                         full,
    output logic                         push_drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt;
    logic              push_ok;

    assign empty     = (cnt == '0);
    assign full      = (cnt == CW'(DEPTH));
    assign push_ok   = push && (!full || pop);
    assign push_drop = push && full && !pop;
    assign head      = mem[rd_ptr];
    assign level     = cnt;

    // Store an accepted frame at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)     rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(level));
endmodule

// File: rtl/serrx_sticky.sv
// One sticky status flag. Set has priority over clear in the same cycle.
module serrx_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until a clear without a concurrent set.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= set || (flag && !clr);
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    // R5
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/serrx_irq_ctrl.sv
// Receive queue with interrupt sources and a register bus.
// Assumes one bus access per cycle, read data used combinationally, and
// DEPTH >= 2. Read side effects land on the next rising edge.
module serrx_irq_ctrl
    import serrx_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 8,
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              contend_evt,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int TW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [TW-1:0] THR_MAX = TW'(DEPTH-1);

    reg_addr_e           addr;
    logic                rd, wr;
    logic                rd_data, pop_en, rd_empty, thr_we;
    logic [TW-1:0]       thr_q;
    logic [NSRC-1:0]     mask_q;
    logic [NSRC-1:0]     raw;
    logic [NSRC-1:0]     set_v, clr_v;
    logic [DATA_W-1:0]   head;
    logic [CW-1:0]       level;
    logic                empty, full, push_drop;

    assign addr     = reg_addr_e'(bus_addr);
    assign rd       = bus_sel && !bus_wr;
    assign wr       = bus_sel && bus_wr;
    assign rd_data  = rd && (addr == A_DATA);
    assign pop_en   = rd_data && !empty;
    assign rd_empty = rd_data && empty;
    assign thr_we   = wr && (addr == A_THR);

    serrx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push_valid), .push_data(push_data), .pop(pop_en),
        .head(head), .level(level), .empty(empty), .full(full),
        .push_drop(push_drop)
    );

    // Programmable threshold (saturating) and source enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q  <= '0;
            mask_q <= '0;
        end else if (wr) begin
            if (addr == A_THR)
                thr_q <= (bus_wdata > 32'(DEPTH-1)) ? THR_MAX : bus_wdata[TW-1:0];
            if (addr == A_MASK)
                mask_q <= bus_wdata[NSRC-1:0];
        end
    end

    // Set and clear events for the sticky sources.
    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[IDX_OVF] = push_drop;
        set_v[IDX_UNF] = rd_empty;
        set_v[IDX_CON] = contend_evt;
        clr_v[IDX_OVF] = rd && (addr == A_OVF_CLR);
        clr_v[IDX_UNF] = rd && (addr == A_UNF_CLR);
        clr_v[IDX_CON] = rd && (addr == A_CON_CLR);
    end

    // Threshold source follows the fill level.
    assign raw[IDX_THR] = (level > CW'(thr_q));

    // Sticky sources; contention only in master builds.
    for (genvar gi = 1; gi < NSRC; gi++) begin : g_sticky
        if (gi == IDX_CON && !IS_MASTER) begin : g_absent
            assign raw[gi] = 1'b0;
        end else begin : g_flag
            serrx_sticky i_flag (
                .clk(clk), .rst_n(rst_n),
                .set(set_v[gi]), .clr(clr_v[gi]), .flag(raw[gi])
            );
        end
    end

    // Combined interrupt line.
    assign irq = |(raw & mask_q);

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (addr)
                A_DATA:    bus_rdata = empty ? '0 : 32'(head);
                A_THR:     bus_rdata = 32'(thr_q);
                A_MASK:    bus_rdata = 32'(mask_q);
                A_RAW:     bus_rdata = 32'(raw);
                A_MSTAT:   bus_rdata = 32'(raw & mask_q);
                A_OVF_CLR: bus_rdata = 32'(raw[IDX_OVF]);
                A_UNF_CLR: bus_rdata = 32'(raw[IDX_UNF]);
                A_CON_CLR: bus_rdata = 32'(raw[IDX_CON]);
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R6
    empty_read_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty |=> raw[IDX_UNF]);
    // R2
    thr_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw[IDX_THR]) |-> ($past(pop_en) || $past(thr_we)));
endmodule

// File: tb/test_serrx_irq_ctrl.sv
module test_serrx_irq_ctrl;
    localparam int DW  = 12;
    localparam int DEP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_valid = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          contend_evt = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int n_chk = 0, n_fail = 0;
    bit running = 0, done = 0;

    int q[$];
    bit m_ovf, m_unf, m_con;
    int m_thr;
    bit [3:0] m_mask;

    serrx_irq_ctrl #(.DATA_W(DW), .DEPTH(DEP), .IS_MASTER(1'b1)) i_serrx_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .contend_evt(contend_evt), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic bit [3:0] m_raw();
        return {m_con, m_unf, m_ovf, (q.size() > m_thr)};
    endfunction

    function automatic bit [31:0] m_read(input bit [2:0] a);
        case (a)
            3'd0: return (q.size() > 0) ? 32'(q[0]) : 32'd0;
            3'd1: return 32'(m_thr);
            3'd2: return 32'(m_mask);
            3'd3: return 32'(m_raw());
            3'd4: return 32'(m_raw() & m_mask);
            3'd5: return 32'(m_ovf);
            3'd6: return 32'(m_unf);
            default: return 32'(m_con);
        endcase
    endfunction

    task automatic chk(input bit [31:0] act, input bit [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R9: interrupt line compared with the model on every clock.
    always @(negedge clk) begin
        if (running) chk(32'(irq), 32'(|(m_raw() & m_mask)), "R9 irq");
    end

    task automatic op(input bit sel, input bit w, input bit [2:0] a, input bit [31:0] wd,
                      input bit psh, input bit [DW-1:0] pd, input bit con, input string tag);
        bit rdd, pop, ovf_set, unf_set;
        @(negedge clk);
        bus_sel = sel; bus_wr = w; bus_addr = a; bus_wdata = wd;
        push_valid = psh; push_data = pd; contend_evt = con;
        #1;
        if (sel && !w) chk(bus_rdata, m_read(a), tag);
        rdd     = sel && !w && a == 3'd0;
        pop     = rdd && q.size() > 0;
        unf_set = rdd && q.size() == 0;
        ovf_set = psh && q.size() == DEP && !pop;
        @(posedge clk);
        #1;
        if (sel && !w && a == 3'd5) m_ovf = 0;
        if (sel && !w && a == 3'd6) m_unf = 0;
        if (sel && !w && a == 3'd7) m_con = 0;
        if (ovf_set) m_ovf = 1;
        if (unf_set) m_unf = 1;
        if (con) m_con = 1;
        if (pop) void'(q.pop_front());
        if (psh && !ovf_set) q.push_back(int'(pd));
        if (sel && w && a == 3'd1) m_thr = (wd > DEP-1) ? DEP-1 : int'(wd);
        if (sel && w && a == 3'd2) m_mask = wd[3:0];
        bus_sel = 0; bus_wr = 0; push_valid = 0; contend_evt = 0;
    endtask

    task automatic rd(input bit [2:0] a, input string tag);
        op(1, 0, a, 0, 0, 0, 0, tag);
    endtask
    task automatic wrr(input bit [2:0] a, input bit [31:0] d);
        op(1, 1, a, d, 0, 0, 0, "wr");
    endtask
    task automatic push(input bit [DW-1:0] d);
        op(0, 0, 0, 0, 1, d, 0, "push");
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        running = 1;
        // R11: reset state of every register.
        for (int a = 0; a < 8; a++) rd(3'(a), "R11 reset");
        wrr(3'd2, 32'hF);
        // R2: threshold source at threshold plus one.
        wrr(3'd1, 1);
        push(12'hA11); rd(3'd3, "R2 below");
        push(12'hB22); rd(3'd3, "R2 at level");
        // R1: order and zero-extended data.
        rd(3'd0, "R1 first");
        rd(3'd3, "R2 self clear");
        rd(3'd0, "R1 second");
        // R3: saturation of the threshold.
        wrr(3'd1, 9); rd(3'd1, "R3 saturate");
        wrr(3'd1, 2); rd(3'd1, "R3 plain");
        // R4: fill, overflow drop, then push with concurrent pop.
        push(12'hFFF); push(12'h001); push(12'h802); push(12'h7E3);
        push(12'h555); rd(3'd3, "R4 overflow raw");
        rd(3'd5, "R5 read flag");
        rd(3'd5, "R5 cleared");
        op(1, 0, 3'd0, 0, 1, 12'h444, 0, "R4 pop while full");
        for (int i = 0; i < 4; i++) rd(3'd0, "R4 contents");
        // R6: empty read, then pointer intact.
        rd(3'd0, "R6 empty zero");
        rd(3'd3, "R6 flag raw");
        push(12'h369); rd(3'd0, "R6 next frame");
        // R7
        rd(3'd6, "R7 read flag");
        rd(3'd6, "R7 cleared");
        // R8
        op(0, 0, 0, 0, 0, 0, 1, "con");
        rd(3'd3, "R8 raw"); rd(3'd7, "R8 read flag"); rd(3'd7, "R8 cleared");
        // R9: partial enables and masked status.
        wrr(3'd2, 32'h8);
        rd(3'd0, "R9 empty"); rd(3'd4, "R9 masked");
        op(0, 0, 0, 0, 0, 0, 1, "con");
        rd(3'd4, "R9 masked con");
        // R10: set and clear in the same cycle.
        op(1, 0, 3'd7, 0, 0, 0, 1, "R10 con clear+set");
        rd(3'd7, "R10 con stays");
        rd(3'd0, "R10 unf read");
        op(1, 0, 3'd6, 0, 0, 0, 0, "R7 clr");
        for (int i = 0; i < 4; i++) push(12'(i * 3 + 1));
        op(1, 0, 3'd5, 0, 1, 12'h0AA, 0, "R10 ovf clear+set");
        rd(3'd5, "R10 ovf stays");
        wrr(3'd2, 0);
        rd(3'd4, "R9 all masked");
        running = 0;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule